// File: doc/BRIEF.md
# Ping-Pong Compressor Switch

This block sits in front of two identical pipelined trace compression engines and steers the sampled bus stream between them, so that starting a new trace segment costs no bus cycle. One engine is always the input engine and takes every incoming sample. When a segment trigger is accepted, input acceptance moves to the other engine in the same cycle. The engine that was just relieved keeps running without new input until its pipeline has drained. Then it gets a one-cycle clear, and the output multiplexer turns to the new engine.

The engine pipeline depth is a parameter, `PIPE_D` (default 4). The clear and the output switch land `PIPE_D` cycles after the accepted trigger. A trigger that arrives while that drain window is still open is not dropped. It is held and taken in the first cycle after the window closes, and any number of triggers inside one window merge into a single held trigger.

For test and integration, the datapath carries a stand-in engine of `PIPE_D` plain register stages. This stand-in has the same latency and clear behaviour as a real compressor, so the merged output stream can be compared directly against the input stream.

Top module: `pingpong_switch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, engine 0 is the input engine (`engEn` = 2'b01 with no trigger), `engRst` is 2'b00, `outSel` is 0 (engine 0) and `traceValid` is 0.
- R2: In every cycle exactly one bit of `engEn` is high. Bit 0 enables engine 0 and bit 1 enables engine 1. Without an accepted trigger, the input engine stays the same as in the previous cycle.
- R3: A trigger arriving while no drain window is open is accepted in that same cycle. `engEn` switches to the other engine combinationally in that cycle, and that cycle's `busData` goes to the new engine. Successive accepted triggers alternate between the two engines.
- R4: Every `busData` sample presented in cycle c leaves on `traceOut` with `traceValid` high in cycle c+`PIPE_D`, in input order, across any number of switches. During the first `PIPE_D` cycles after reset, `traceValid` is 0.
- R5: For a trigger accepted in cycle T, `engRst` goes high for exactly cycle T+`PIPE_D`, on the bit of the engine that was the input engine before T. In that same cycle `outSel` changes to the engine enabled at T (0 = engine 0, 1 = engine 1). `outSel` changes at no other time.
- R6: The drain window covers cycles T+1 to T+`PIPE_D`. A trigger seen inside it is held and accepted in cycle T+`PIPE_D`+1, even if the trigger input is low by then. Several triggers inside one window produce a single switch.
- R7: An engine never receives its clear in a cycle where it is enabled. The engine not selected by `outSel` never holds a valid sample in its last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Segment trigger strobe |
| busData | input | DATA_W | Sampled bus word, one per cycle |
| engEn | output | 2 | Per-engine input enable, one-hot |
| engRst | output | 2 | Per-engine one-cycle clear |
| outSel | output | 1 | Output multiplexer select (engine index) |
| traceOut | output | DATA_W | Word leaving the selected engine |
| traceValid | output | 1 | `traceOut` carries a sample |

## Verification
A wrong input-engine state shows in the same cycle as a wrong `engEn` bit. Since every cycle is accepted, it also shows `PIPE_D` cycles later as a missing, duplicated or reordered word on `traceOut`. A drain counter that is off by one moves the `engRst` pulse and the `outSel` change away from T+`PIPE_D`. That either clears an engine that still holds data, which drops words on the output `PIPE_D` cycles after the trigger, or shows up directly as a pulse in the wrong cycle. A lost or doubled held trigger shows as a missing or extra `engEn` flip in cycle T+`PIPE_D`+1.

// File: rtl/ppsw_pkg.sv
package ppsw_pkg;

  // Strobes from the switch control to the engine datapath.
  typedef struct packed {
    logic [1:0] en;   // input acceptance per engine
    logic [1:0] clr;  // one-cycle clear per engine
    logic       sel;  // output mux: engine index
  } ppStrobe_t;

endpackage

// File: rtl/ppsw_engine.sv
// Stand-in compression engine: PIPE_D register stages with a valid bit.
module ppsw_engine #(
  parameter int DATA_W = 16,
  parameter int PIPE_D = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              clr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              vout
);

  logic [DATA_W-1:0] stData [PIPE_D];
  logic              stVld  [PIPE_D];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PIPE_D; i++) begin
        stData[i] <= '0;
        stVld[i]  <= 1'b0;
      end
    end else if (clr) begin
      for (int i = 0; i < PIPE_D; i++) begin
        stData[i] <= '0;
        stVld[i]  <= 1'b0;
      end
    end else begin
      stVld[0]  <= en;
      stData[0] <= en ? din : '0;
      for (int i = 1; i < PIPE_D; i++) begin
        stVld[i]  <= stVld[i-1];
        stData[i] <= stData[i-1];
      end
    end
  end

  assign dout = stData[PIPE_D-1];
  assign vout = stVld[PIPE_D-1];

  // R7: a clear never lands on an engine that is taking input
  assert_clr_not_enabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    clr |-> !en);

endmodule

// File: rtl/ppsw_ctrl.sv
// Switch control: input engine choice, drain counting, held trigger.
module ppsw_ctrl
  import ppsw_pkg::*;
#(
  parameter int PIPE_D = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      trigIn,
  output ppStrobe_t strobe
);

  localparam int CNT_W = $clog2(PIPE_D + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PIPE_D);
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(PIPE_D - 1);

  logic             activeSel;  // current input engine
  logic             busy;       // drain window open
  logic             heldTrig;   // trigger waiting for the window to close
  logic             selQ;
  logic [1:0]       clrQ;
  logic [CNT_W-1:0] cnt;
  logic             go;
  logic             nextActive;

  assign go         = (trigIn || heldTrig) && !busy;
  assign nextActive = activeSel ^ go;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSel <= 1'b0;
      busy      <= 1'b0;
      heldTrig  <= 1'b0;
      selQ      <= 1'b0;
      clrQ      <= 2'b00;
      cnt       <= '0;
    end else begin
      clrQ <= 2'b00;
      if (go) begin
        activeSel <= ~activeSel;
        busy      <= 1'b1;
        cnt       <= CNT_W'(1);
        heldTrig  <= 1'b0;
      end else begin
        heldTrig <= heldTrig || trigIn;
        if (busy) begin
          if (cnt == CNT_LAST) busy <= 1'b0;
          else                 cnt  <= cnt + CNT_W'(1);
        end
      end
      // last drain cycle next: clear the old engine, point output at the new one
      if (busy && cnt == CNT_PRE) begin
        clrQ <= activeSel ? 2'b01 : 2'b10;
        selQ <= activeSel;
      end
    end
  end

  assign strobe.en  = nextActive ? 2'b10 : 2'b01;
  assign strobe.clr = clrQ;
  assign strobe.sel = selQ;

  // R5: the clear is a single-cycle pulse
  assert_clr_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clr != 2'b00) |=> (strobe.clr == 2'b00));

  // R5: the output select moves only together with a clear
  assert_sel_with_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel != $past(strobe.sel)) |-> (strobe.clr != 2'b00));

  // R7: never clear and enable the same engine
  assert_clr_en_disjoint_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clr & strobe.en) == 2'b00);

  // R6: a trigger inside the window is remembered into the next cycle
  assert_trig_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn && busy && !(cnt == CNT_LAST)) |=> heldTrig);

endmodule

// File: rtl/ppsw_path.sv
// Engine datapath: two stand-in engines and the output multiplexer.
module ppsw_path
  import ppsw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PIPE_D = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busData,
  input  ppStrobe_t         strobe,
  output logic [DATA_W-1:0] traceOut,
  output logic              traceValid
);

  localparam int ENG_N = 2;

  logic [DATA_W-1:0] engOut [ENG_N];
  logic [ENG_N-1:0]  engVld;
  logic              unSel;

  for (genvar g = 0; g < ENG_N; g++) begin : gEng
    ppsw_engine #(.DATA_W(DATA_W), .PIPE_D(PIPE_D)) uEngine (
      .clk  (clk),
      .rstN (rstN),
      .en   (strobe.en[g]),
      .clr  (strobe.clr[g]),
      .din  (busData),
      .dout (engOut[g]),
      .vout (engVld[g])
    );
  end

  assign unSel      = ~strobe.sel;
  assign traceOut   = engOut[strobe.sel];
  assign traceValid = engVld[strobe.sel];

  // R7: the engine hidden by the mux never has a sample ready
  assert_no_stranded_R7: assert property (@(posedge clk) disable iff (!rstN)
    !engVld[unSel]);

endmodule

// File: rtl/pingpong_switch.sv
module pingpong_switch
  import ppsw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PIPE_D = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic [DATA_W-1:0] busData,
  output logic [1:0]        engEn,
  output logic [1:0]        engRst,
  output logic              outSel,
  output logic [DATA_W-1:0] traceOut,
  output logic              traceValid
);

  ppStrobe_t strobe;

  ppsw_ctrl #(.PIPE_D(PIPE_D)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .trigIn (trigIn),
    .strobe (strobe)
  );

  ppsw_path #(.DATA_W(DATA_W), .PIPE_D(PIPE_D)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .busData    (busData),
    .strobe     (strobe),
    .traceOut   (traceOut),
    .traceValid (traceValid)
  );

  assign engEn  = strobe.en;
  assign engRst = strobe.clr;
  assign outSel = strobe.sel;

endmodule

// File: tb/pingpong_switch_test.sv
module pingpong_switch_test;

  localparam int DATA_W = 16;
  localparam int PIPE_D = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              trigIn;
  logic [DATA_W-1:0] busData;
  logic [1:0]        engEn;
  logic [1:0]        engRst;
  logic              outSel;
  logic [DATA_W-1:0] traceOut;
  logic              traceValid;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // bench model state, built from the requirements
  bit                mActive, mBusy, mHeld, mSel;
  int                mCnt;
  int                cyc;
  logic [DATA_W-1:0] hist [16];

  always #4 clk = ~clk;  // 125 MHz

  pingpong_switch #(.DATA_W(DATA_W), .PIPE_D(PIPE_D)) uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .busData(busData),
    .engEn(engEn), .engRst(engRst), .outSel(outSel),
    .traceOut(traceOut), .traceValid(traceValid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  function automatic logic [1:0] oneHot(input bit idx);
    return idx ? 2'b10 : 2'b01;
  endfunction

  // one cycle: drive at the falling edge, check, advance the model
  task automatic runCycle(input bit trig, input logic [DATA_W-1:0] d);
    bit go, fin;
    string enTag;
    logic [1:0] expRst;
    bit expSel;
    trigIn  = trig;
    busData = d;
    #1;
    go  = (trig || mHeld) && !mBusy;
    fin = mBusy && (mCnt == PIPE_D);
    expRst = fin ? oneHot(!mActive) : 2'b00;
    expSel = fin ? mActive : mSel;
    enTag  = go ? (mHeld ? "R6" : "R3") : "R2";
    chk(engEn == oneHot(mActive ^ go), enTag, "engEn", 32'(engEn), 32'(oneHot(mActive ^ go)));
    chk(engRst == expRst, "R5", "engRst", 32'(engRst), 32'(expRst));
    chk(outSel == expSel, "R5", "outSel", 32'(outSel), 32'(expSel));
    if (cyc < PIPE_D) begin
      chk(traceValid == 1'b0, "R4", "traceValid early", 32'(traceValid), 32'd0);
    end else begin
      chk(traceValid == 1'b1, "R4", "traceValid", 32'(traceValid), 32'd1);
      chk(traceOut == hist[(cyc - PIPE_D) % 16], "R4", "traceOut",
          32'(traceOut), 32'(hist[(cyc - PIPE_D) % 16]));
    end
    hist[cyc % 16] = d;
    if (fin) mSel = mActive;
    if (go) begin
      mActive = !mActive;
      mBusy   = 1;
      mCnt    = 1;
      mHeld   = 0;
    end else begin
      mHeld = mHeld || trig;
      if (mBusy) begin
        if (mCnt == PIPE_D) mBusy = 0;
        else                mCnt++;
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) runCycle(1'b0, DATA_W'($urandom));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; trigIn = 1'b0; busData = '0;
    mActive = 0; mBusy = 0; mHeld = 0; mSel = 0; mCnt = 0; cyc = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1: state held in reset
    chk(engEn == 2'b01, "R1", "engEn in reset", 32'(engEn), 32'd1);
    chk(engRst == 2'b00, "R1", "engRst in reset", 32'(engRst), 32'd0);
    chk(outSel == 1'b0, "R1", "outSel in reset", 32'(outSel), 32'd0);
    chk(traceValid == 1'b0, "R1", "traceValid in reset", 32'(traceValid), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: first cycle after reset, trigger-free
    runCycle(1'b0, 16'hA001);
    idle(6);
    // single trigger and full drain (R3, R5)
    runCycle(1'b1, 16'hB002);
    idle(8);
    // second trigger returns to engine 0 (R3)
    runCycle(1'b1, 16'hB003);
    idle(8);
    // spacing sweep around the drain window (R6)
    for (int gap = 1; gap <= PIPE_D + 3; gap++) begin
      runCycle(1'b1, DATA_W'($urandom));
      idle(gap - 1);
      runCycle(1'b1, DATA_W'($urandom));
      idle(2 * PIPE_D + 2);
    end
    // trigger held high for many cycles: merged held triggers (R6)
    for (int i = 0; i < 12; i++) runCycle(1'b1, DATA_W'($urandom));
    idle(2 * PIPE_D + 2);
    // constrained random traffic
    for (int i = 0; i < 4000; i++) runCycle(($urandom % 4) == 0, DATA_W'($urandom));
    idle(2 * PIPE_D + 2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule